// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialization Controller

This block keeps a 4096-row EDO DRAM refreshed and brings it up after power-on. After reset it waits out the power-up pause. It then asks the access arbiter for the memory bus and, once granted, runs a train of CAS-before-RAS refresh cycles. When the last of that train finishes, it declares the memory ready. From then on an interval timer adds one owed refresh every distributed-refresh period, which is about 15.6 us at a 10 ns clock (4096 rows in 64 ms). Each owed refresh raises a bus request toward the arbiter. The DRAM's internal row counter selects the row, so the block drives only the RAS, CAS and WE strobes and never an address.

If the arbiter is slow to grant, owed refreshes pile up in a saturating counter. When the grant arrives, all of them are issued back to back under that single grant. A sleep request, made after initialization, puts the DRAM into self-refresh: a CAS-before-RAS entry with both strobes held low for at least the minimum self-refresh time. When the sleep request is released, the block runs the long exit precharge and then, still under the same bus ownership, the one refresh that must follow self-refresh. All timing is expressed in clock cycles through parameters.

Top module: `refc_top`

## Requirements
- R1: During and straight after reset, ras_n_o, cas_n_o and we_n_o are 1, and ref_req_o, busy_o, init_done_o, sleep_ack_o and owed_o are all 0.
- R2: ref_req_o stays 0 for at least INIT_PAUSE_CYC cycles after reset is released.
- R3: After the pause, one grant starts exactly INIT_CBR refresh cycles that run back to back with busy_o held at 1. init_done_o rises in the same cycle that busy_o falls, and it never falls afterwards.
- R4: ref_req_o is registered. Once it is 1, it stays 1 until grant_i is seen at 1 on a clock edge, and it is 0 in the following cycle, in which busy_o is 1. A grant_i pulse while ref_req_o is 0 starts nothing.
- R5: In every refresh cycle, cas_n_o falls CSR_CYC cycles before ras_n_o falls. ras_n_o then stays 0 for RAS_CYC cycles. cas_n_o stays 0 for CHR_CYC cycles after ras_n_o falls, so CAS is low for CSR_CYC+CHR_CYC cycles in all. we_n_o is 1 at all times.
- R6: Between two back-to-back refresh cycles, ras_n_o stays 1 for RP_CYC+CSR_CYC cycles. Whenever busy_o is 0, ras_n_o and cas_n_o are both 1.
- R7: After init_done_o, one refresh becomes owed every REF_INT_CYC cycles.
- R8: owed_o counts owed refreshes that have not yet been issued. It rises by one per interval while no grant comes, never exceeds MAX_OWED, and is cleared during self-refresh.
- R9: After a grant, every owed refresh is issued under that grant without busy_o falling. owed_o is 0 when busy_o falls.
- R10: With init_done_o at 1, sleep_req_i at 1 leads to a request. On the grant the block enters self-refresh: sleep_ack_o is 1 and ras_n_o and cas_n_o are both 0. ref_req_o stays 0 while the block is in self-refresh.
- R11: In self-refresh, ras_n_o stays 0 for at least SELF_MIN_CYC cycles, even if sleep_req_i falls earlier. If sleep_req_i falls early, ras_n_o is low for exactly SELF_MIN_CYC cycles.
- R12: On exit from self-refresh, ras_n_o stays 1 for RPS_CYC+CSR_CYC cycles. Exactly one refresh cycle follows with no new request, and busy_o falls after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| grant_i | input | 1 | Bus grant from the access arbiter |
| sleep_req_i | input | 1 | Request to enter (1) or leave (0) self-refresh |
| ref_req_o | output | 1 | Bus request to the arbiter |
| busy_o | output | 1 | Block owns the DRAM strobes |
| init_done_o | output | 1 | Power-up sequence complete, memory ready |
| sleep_ack_o | output | 1 | DRAM is in self-refresh |
| owed_o | output | $clog2(MAX_OWED+1) | Number of refreshes owed |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low, held high |

## Verification
The assertions assume that the arbiter, once it grants, lets the block keep the DRAM until busy_o falls. They also assume that sleep_req_i is meaningful only after init_done_o. No assumption is made about when grant_i arrives, so the handshake properties must hold for any grant timing. The bench keeps to these limits. It drives grant_i either straight from ref_req_o or as single-cycle pulses after long deliberate delays, and it holds sleep_req_i steady until sleep_ack_o or the end of the self-refresh check.

// File: rtl/refc_pkg.sv
package refc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSR,
    ST_RAS,
    ST_PRE,
    ST_SELF,
    ST_SXP
  } refc_state_e;

  function automatic int refc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/refc_tick.sv
module refc_tick #(
  parameter int PERIOD = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int W = $clog2(PERIOD + 1);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/refc_owed.sv
module refc_owed #(
  parameter int MAX_OWED = 8,
  localparam int W = $clog2(MAX_OWED + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         nz_o
);
  localparam logic [W-1:0] MAXV = W'(MAX_OWED);

  logic [W-1:0] cnt_q;
  logic up, down;

  // a take in the same cycle as a tick consumes that tick
  assign up   = inc_i && (cnt_q != MAXV);
  assign down = dec_i && ((cnt_q != '0) || inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (up && !down) cnt_q <= cnt_q + 1'b1;
    else if (down && !up) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
  assign nz_o  = (cnt_q != '0);
endmodule

// File: rtl/refc_seq.sv
module refc_seq
  import refc_pkg::*;
#(
  parameter int INIT_CBR     = 8,
  parameter int CSR_CYC      = 1,
  parameter int RAS_CYC      = 6,
  parameter int CHR_CYC      = 1,
  parameter int RP_CYC       = 4,
  parameter int RPS_CYC      = 11,
  parameter int SELF_MIN_CYC = 10001
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pause_done_i,
  input  logic owed_nz_i,
  input  logic sleep_req_i,
  input  logic grant_i,
  output logic ref_req_o,
  output logic busy_o,
  output logic init_done_o,
  output logic sleep_ack_o,
  output logic in_self_o,
  output logic take_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int DMAX = refc_max(refc_max(CSR_CYC, RAS_CYC),
                                 refc_max(refc_max(RP_CYC, RPS_CYC), SELF_MIN_CYC));
  localparam int CW = $clog2(DMAX + 1);
  localparam int IW = $clog2(INIT_CBR + 1);
  localparam logic [CW-1:0] CSR_L  = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] RAS_L  = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] RP_L   = CW'(RP_CYC - 1);
  localparam logic [CW-1:0] RPS_L  = CW'(RPS_CYC - 1);
  localparam logic [CW-1:0] SELF_L = CW'(SELF_MIN_CYC - 1);
  localparam logic [CW-1:0] CHR_V  = CW'(CHR_CYC);

  refc_state_e  state_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] init_left_q;
  logic          req_q, self_mode_q, init_done_q;
  logic          last, want, grant_take, pre_end;

  always_comb begin
    unique case (state_q)
      ST_CSR:  last = (cnt_q == CSR_L);
      ST_RAS:  last = (cnt_q == RAS_L);
      ST_PRE:  last = (cnt_q == RP_L);
      ST_SXP:  last = (cnt_q == RPS_L);
      ST_SELF: last = (cnt_q == SELF_L);
      default: last = 1'b0;
    endcase
  end

  assign want       = init_done_q ? (sleep_req_i || owed_nz_i) : pause_done_i;
  assign grant_take = (state_q == ST_IDLE) && req_q && grant_i;
  assign pre_end    = (state_q == ST_PRE) && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                             cnt_q <= '0;
    else if (state_q == ST_IDLE)                             cnt_q <= '0;
    else if ((state_q == ST_SELF) && last && sleep_req_i)    cnt_q <= cnt_q;
    else if (last)                                           cnt_q <= '0;
    else                                                     cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      req_q       <= 1'b0;
      self_mode_q <= 1'b0;
      init_done_q <= 1'b0;
      init_left_q <= IW'(INIT_CBR);
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (grant_take) begin
            req_q       <= 1'b0;
            state_q     <= ST_CSR;
            self_mode_q <= init_done_q && sleep_req_i;
            if (!init_done_q) init_left_q <= init_left_q - 1'b1;
          end else if (want) begin
            req_q <= 1'b1;
          end
        end
        ST_CSR: if (last) state_q <= self_mode_q ? ST_SELF : ST_RAS;
        ST_RAS: if (last) state_q <= ST_PRE;
        ST_PRE: begin
          if (last) begin
            if (!init_done_q) begin
              if (init_left_q != '0) begin
                state_q     <= ST_CSR;
                init_left_q <= init_left_q - 1'b1;
              end else begin
                state_q     <= ST_IDLE;
                init_done_q <= 1'b1;
              end
            end else if (owed_nz_i) begin
              state_q <= ST_CSR;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_SELF: if (last && !sleep_req_i) state_q <= ST_SXP;
        ST_SXP: begin
          if (last) begin
            state_q     <= ST_CSR;   // mandatory refresh after exit
            self_mode_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign take_o = (grant_take && init_done_q && !sleep_req_i) ||
                  (pre_end && init_done_q && owed_nz_i);

  assign ref_req_o   = req_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign init_done_o = init_done_q;
  assign sleep_ack_o = (state_q == ST_SELF);
  assign in_self_o   = (state_q == ST_SELF) || (state_q == ST_SXP);
  assign ras_n_o     = !((state_q == ST_RAS) || (state_q == ST_SELF));
  assign cas_n_o     = !((state_q == ST_CSR) || (state_q == ST_SELF) ||
                         ((state_q == ST_RAS) && (cnt_q < CHR_V)));
endmodule

// File: rtl/refc_top.sv
module refc_top #(
  parameter int INIT_PAUSE_CYC = 20000,
  parameter int REF_INT_CYC    = 1560,
  parameter int MAX_OWED       = 8,
  parameter int INIT_CBR       = 8,
  parameter int CSR_CYC        = 1,
  parameter int RAS_CYC        = 6,
  parameter int CHR_CYC        = 1,
  parameter int RP_CYC         = 4,
  parameter int RPS_CYC        = 11,
  parameter int SELF_MIN_CYC   = 10001,
  localparam int OW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          grant_i,
  input  logic          sleep_req_i,
  output logic          ref_req_o,
  output logic          busy_o,
  output logic          init_done_o,
  output logic          sleep_ack_o,
  output logic [OW-1:0] owed_o,
  output logic          ras_n_o,
  output logic          cas_n_o,
  output logic          we_n_o
);
  logic pause_done_q, pause_tick, ref_tick;
  logic owed_nz, take, in_self;

  refc_tick #(.PERIOD(INIT_PAUSE_CYC)) u_pause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (!pause_done_q),
    .tick_o (pause_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pause_done_q <= 1'b0;
    else if (pause_tick) pause_done_q <= 1'b1;
  end

  refc_tick #(.PERIOD(REF_INT_CYC)) u_interval (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (init_done_o),
    .tick_o (ref_tick)
  );

  refc_owed #(.MAX_OWED(MAX_OWED)) u_owed (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ref_tick && !in_self),
    .dec_i  (take),
    .clr_i  (in_self),
    .cnt_o  (owed_o),
    .nz_o   (owed_nz)
  );

  refc_seq #(
    .INIT_CBR     (INIT_CBR),
    .CSR_CYC      (CSR_CYC),
    .RAS_CYC      (RAS_CYC),
    .CHR_CYC      (CHR_CYC),
    .RP_CYC       (RP_CYC),
    .RPS_CYC      (RPS_CYC),
    .SELF_MIN_CYC (SELF_MIN_CYC)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pause_done_i (pause_done_q),
    .owed_nz_i    (owed_nz),
    .sleep_req_i  (sleep_req_i),
    .grant_i      (grant_i),
    .ref_req_o    (ref_req_o),
    .busy_o       (busy_o),
    .init_done_o  (init_done_o),
    .sleep_ack_o  (sleep_ack_o),
    .in_self_o    (in_self),
    .take_o       (take),
    .ras_n_o      (ras_n_o),
    .cas_n_o      (cas_n_o)
  );

  assign we_n_o = 1'b1;
endmodule

// File: rtl/refc_chk.sv
module refc_chk #(
  parameter int MAX_OWED = 8,
  localparam int OW = $clog2(MAX_OWED + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          grant_i,
  input logic          ref_req_o,
  input logic          busy_o,
  input logic          init_done_o,
  input logic          sleep_ack_o,
  input logic [OW-1:0] owed_o,
  input logic          ras_n_o,
  input logic          cas_n_o
);
  localparam logic [OW-1:0] MAXV = OW'(MAX_OWED);

  assert_req_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o && grant_i |=> !ref_req_o && busy_o);

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o && !grant_i |=> ref_req_o);

  assert_cas_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> !cas_n_o && !$past(cas_n_o));

  assert_precharge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |=> ras_n_o);

  assert_idle_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ras_n_o && cas_n_o);

  assert_ready_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> !busy_o);

  assert_ready_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(init_done_o));

  assert_owed_max_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owed_o <= MAXV);

  assert_owed_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owed_o > $past(owed_o)) |-> (owed_o == $past(owed_o) + 1'b1));

  assert_self_strobes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_ack_o |-> !ras_n_o && !cas_n_o && init_done_o && !ref_req_o);
endmodule

bind refc_top refc_chk #(.MAX_OWED(MAX_OWED)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .grant_i     (grant_i),
  .ref_req_o   (ref_req_o),
  .busy_o      (busy_o),
  .init_done_o (init_done_o),
  .sleep_ack_o (sleep_ack_o),
  .owed_o      (owed_o),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o)
);

// File: tb/tb_refc_top.sv
module tb_refc_top;
  localparam int P_PAUSE = 50, P_INT = 64, P_MAXO = 4, P_INIT = 8;
  localparam int P_CSR = 1, P_CHR = 1, P_RAS = 6, P_RP = 4, P_RPS = 11, P_SELF = 30;
  localparam int OW = $clog2(P_MAXO + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic auto_gnt = 1'b0, man_gnt = 1'b0, sleep_req = 1'b0;
  logic grant;
  logic ref_req, busy, init_done, sleep_ack, ras_n, cas_n, we_n;
  logic [OW-1:0] owed;

  assign grant = auto_gnt ? ref_req : man_gnt;

  refc_top #(
    .INIT_PAUSE_CYC(P_PAUSE), .REF_INT_CYC(P_INT), .MAX_OWED(P_MAXO), .INIT_CBR(P_INIT),
    .CSR_CYC(P_CSR), .RAS_CYC(P_RAS), .CHR_CYC(P_CHR), .RP_CYC(P_RP),
    .RPS_CYC(P_RPS), .SELF_MIN_CYC(P_SELF)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .grant_i(grant), .sleep_req_i(sleep_req),
    .ref_req_o(ref_req), .busy_o(busy), .init_done_o(init_done), .sleep_ack_o(sleep_ack),
    .owed_o(owed), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;

  // strobe monitor, updated on each falling clock edge
  logic ras_p = 1'b1, cas_p = 1'b1, busy_p = 1'b0;
  int ras_lo_run = 0, ras_hi_run = 0, cas_lo_run = 0;
  int last_lo = 0, last_hi = 0, min_hi = 1000, last_cas = 0;
  int cbr_cnt = 0, order_viol = 0, we_viol = 0, busy_falls = 0, req_hi = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n) we_viol++;
      if (ref_req) req_hi++;
      if (busy_p && !busy) busy_falls++;
      if (ras_p && !ras_n) begin
        cbr_cnt++;
        if (cas_p) order_viol++;
        last_hi = ras_hi_run;
        if (ras_hi_run < min_hi) min_hi = ras_hi_run;
      end
      if (!ras_p && ras_n) last_lo = ras_lo_run;
      if (!cas_p && cas_n) last_cas = cas_lo_run;
      ras_lo_run = ras_n ? 0 : (ras_p ? 1 : ras_lo_run + 1);
      ras_hi_run = ras_n ? (ras_p ? ras_hi_run + 1 : 1) : 0;
      cas_lo_run = cas_n ? 0 : (cas_p ? 1 : cas_lo_run + 1);
      ras_p  = ras_n;
      cas_p  = cas_n;
      busy_p = busy;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wait_idle(input int lim);
    int k = 0;
    while (busy && k < lim) begin step(); k++; end
    chk(!busy, "R9 wait for busy_o low", busy, 0);
  endtask

  task automatic grant_pulse();
    man_gnt = 1'b1;
    step();
    man_gnt = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    chk(!ref_req && !busy && !init_done && !sleep_ack, "R1 flags low in reset",
        {ref_req, busy, init_done, sleep_ack}, 0);
    chk(owed == 0, "R1 owed zero in reset", owed, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_init();
    int n = 0, k = 0, c0, bf0;
    while (!ref_req && n < P_PAUSE + 20) begin step(); n++; end
    chk(ref_req && n >= P_PAUSE, "R2 request not before pause", n, P_PAUSE);
    repeat (3) step();
    chk(ref_req && !busy, "R4 request held without grant", ref_req, 1);
    min_hi = 1000;
    c0 = cbr_cnt;
    bf0 = busy_falls;
    grant_pulse();
    chk(!ref_req && busy, "R4 request dropped after grant", ref_req, 0);
    while (!init_done && k < 300) begin step(); k++; end
    chk(init_done, "R3 init_done rises", init_done, 1);
    chk(cbr_cnt - c0 == P_INIT, "R3 init refresh count", cbr_cnt - c0, P_INIT);
    chk(!busy && busy_falls - bf0 == 1, "R3 back to back with one release",
        busy_falls - bf0, 1);
    chk(min_hi == P_RP + P_CSR, "R6 precharge between init cycles", min_hi, P_RP + P_CSR);
    chk(last_lo == P_RAS, "R5 RAS low width", last_lo, P_RAS);
    chk(last_cas == P_CSR + P_CHR, "R5 CAS low width", last_cas, P_CSR + P_CHR);
    chk(order_viol == 0, "R5 CAS falls before RAS", order_viol, 0);
  endtask

  task automatic t_periodic();
    int c0;
    auto_gnt = 1'b1;
    c0 = cbr_cnt;
    repeat (5 * P_INT) step();
    chk((cbr_cnt - c0 >= 4) && (cbr_cnt - c0 <= 6), "R7 one refresh per interval",
        cbr_cnt - c0, 5);
    chk(init_done, "R3 init_done stays high", init_done, 1);
  endtask

  task automatic t_grant_ignored();
    int k = 0, c0, busy_seen = 0;
    while (!busy && k < 2 * P_INT) begin step(); k++; end
    wait_idle(50);
    auto_gnt = 1'b0;
    c0 = cbr_cnt;
    man_gnt = 1'b1;
    repeat (8) begin
      step();
      if (busy || !ras_n) busy_seen++;
    end
    man_gnt = 1'b0;
    chk(busy_seen == 0 && cbr_cnt == c0, "R4 grant without request ignored", busy_seen, 0);
  endtask

  task automatic t_postpone();
    int k = 0, drops = 0, c0, bf0;
    bit seen = 1'b0;
    auto_gnt = 1'b0;
    while (owed != 3 && k < 4 * P_INT + 20) begin
      step(); k++;
      if (ref_req) seen = 1'b1;
      else if (seen) drops++;
    end
    chk(owed == 3, "R8 owed counts missed intervals", owed, 3);
    chk(ref_req && drops == 0, "R4 request held while waiting", drops, 0);
    min_hi = 1000;
    c0 = cbr_cnt;
    bf0 = busy_falls;
    grant_pulse();
    wait_idle(100);
    chk((cbr_cnt - c0 >= 3) && (cbr_cnt - c0 <= 4), "R9 owed issued on one grant",
        cbr_cnt - c0, 3);
    chk(busy_falls - bf0 == 1, "R9 bus kept through backlog", busy_falls - bf0, 1);
    chk(min_hi == P_RP + P_CSR, "R6 back to back precharge", min_hi, P_RP + P_CSR);
    chk(owed == 0, "R9 owed empty at release", owed, 0);
  endtask

  task automatic t_saturate();
    int c0;
    auto_gnt = 1'b0;
    repeat (6 * P_INT + 10) step();
    chk(owed == P_MAXO, "R8 owed saturates", owed, P_MAXO);
    c0 = cbr_cnt;
    grant_pulse();
    wait_idle(120);
    chk((cbr_cnt - c0 >= P_MAXO) && (cbr_cnt - c0 <= P_MAXO + 1), "R9 saturated backlog issued",
        cbr_cnt - c0, P_MAXO);
    chk(owed == 0, "R9 owed empty after backlog", owed, 0);
  endtask

  task automatic t_self_long();
    int k = 0, hi = 0, r0, c0;
    auto_gnt = 1'b1;
    sleep_req = 1'b1;
    while (!sleep_ack && k < 40) begin step(); k++; end
    chk(sleep_ack && !ras_n && !cas_n, "R10 self-refresh entered", {sleep_ack, ras_n, cas_n}, 4);
    r0 = req_hi;
    repeat (P_SELF + 10) begin
      step();
      if (ras_n) hi++;
    end
    chk(hi == 0, "R11 RAS held low in self-refresh", hi, 0);
    chk(req_hi == r0, "R10 no request while in self-refresh", req_hi - r0, 0);
    chk(owed == 0, "R8 owed cleared in self-refresh", owed, 0);
    sleep_req = 1'b0;
    k = 0;
    while (!ras_n && k < P_SELF + 5) begin step(); k++; end
    chk(last_lo >= P_SELF, "R11 self-refresh minimum", last_lo, P_SELF);
    r0 = req_hi;
    c0 = cbr_cnt;
    wait_idle(60);
    chk(cbr_cnt - c0 == 1, "R12 one refresh after exit", cbr_cnt - c0, 1);
    chk(last_hi == P_RPS + P_CSR, "R12 exit precharge", last_hi, P_RPS + P_CSR);
    chk(req_hi == r0, "R12 exit refresh without request", req_hi - r0, 0);
    chk(last_lo == P_RAS, "R12 exit refresh RAS width", last_lo, P_RAS);
  endtask

  task automatic t_self_short();
    int k = 0;
    sleep_req = 1'b1;
    while (!sleep_ack && k < 40) begin step(); k++; end
    chk(sleep_ack, "R10 second entry", sleep_ack, 1);
    repeat (3) step();
    sleep_req = 1'b0;
    k = 0;
    while (!ras_n && k < P_SELF + 5) begin step(); k++; end
    chk(last_lo == P_SELF, "R11 early release held to minimum", last_lo, P_SELF);
    wait_idle(60);
    chk(we_viol == 0, "R5 WE held high", we_viol, 0);
    chk(order_viol == 0, "R5 CAS before RAS throughout", order_viol, 0);
  endtask

  initial begin
    t_reset();
    t_init();
    t_periodic();
    t_grant_ignored();
    t_postpone();
    t_saturate();
    t_self_long();
    t_self_short();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 100000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule